// File: doc/BRIEF.md
# Power and RMS Averaging Engine

This block takes a stream of signed voltage, current and quadrature-voltage samples, one beat per output word. Over each averaging window it builds four 64-bit signed sums: voltage squared, current squared, voltage times current, and current times quadrature voltage. It also tracks the largest voltage and current magnitudes seen. When the window closes, a shared sequential divider turns each sum into a mean. The active and reactive means then get their programmable signed offsets added. All results are presented together with the number of samples used, so a host can take square roots or form power factor downstream.

A window closes in one of two ways. In count mode (`cfg_sync` = 0) it ends after a programmed number of samples. Requests below 100 samples are raised to 100. In line-locked mode (`cfg_sync` = 1) it ends on the sample that carries the programmed number of voltage zero-crossing flags, so the sample count follows line frequency. Both input and output are valid/ready streams. The sample input deasserts `smp_ready` from the window's last sample until the result beat is taken. A result beat holds all of its fields stable while `res_ready` is low. No sample is lost or counted twice across windows. `start` arms the engine. `stop` disarms it and throws away any partly filled window.

Top module: `pwr_avg_engine`

## Requirements
- R1: After reset, `res_valid` and `smp_ready` are 0 and `res_count` is 0 until `start` is pulsed.
- R2: With `cfg_sync` = 0, a window holds exactly max(`cfg_n`, 100) accepted samples, and `res_count` reports that number.
- R3: `res_v2` and `res_i2` equal the sum of squared voltage (current) samples over the window divided by `res_count`, rounded down.
- R4: `res_p` equals the sum of voltage times current over the window divided by `res_count`, truncated toward zero, plus `cfg_p_off`.
- R5: `res_q` equals the sum of current times quadrature voltage divided by `res_count`, truncated toward zero, plus `cfg_q_off`.
- R6: `res_pkv` and `res_pki` are the largest absolute voltage and current values within that window only (the absolute value of -32768 is 32768). Peak tracking restarts with every window.
- R7: With `cfg_sync` = 1, the window ends on the accepted sample whose `smp_zc` flag is the `cfg_hc`-th one since the window began (`cfg_hc` = 0 acts as 1). `cfg_n` has no effect in this mode.
- R8: `smp_ready` is 0 while a result is pending. A result beat holds every field stable until `res_ready` is seen. When the engine stays armed, the next window begins with the next accepted sample, with none lost or counted twice.
- R9: `stop` discards a partly filled window: no result is produced, and the next `start` begins a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arm the engine and open a new window |
| stop | input | 1 | Disarm the engine; drops a partial window |
| cfg_sync | input | 1 | 0: count mode, 1: line-locked mode |
| cfg_n | input | CW (16) | Samples per window in count mode |
| cfg_hc | input | HW (16) | Zero-crossing flags per window in line-locked mode |
| cfg_p_off | input | 2W (32) | Signed active-power offset |
| cfg_q_off | input | 2W (32) | Signed reactive-power offset |
| smp_valid | input | 1 | Sample beat valid |
| smp_ready | output | 1 | Engine can accept a sample |
| smp_v | input | W (16) | Signed voltage sample |
| smp_i | input | W (16) | Signed current sample |
| smp_q | input | W (16) | Signed 90-degree-shifted voltage sample |
| smp_zc | input | 1 | Voltage zero crossing occurred on this beat |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Downstream takes the result beat |
| res_v2 | output | 2W (32) | Mean of voltage squared |
| res_i2 | output | 2W (32) | Mean of current squared |
| res_p | output | 2W+1 (33) | Signed mean active power plus offset |
| res_q | output | 2W+1 (33) | Signed mean reactive power plus offset |
| res_pkv | output | W (16) | Peak absolute voltage in the window |
| res_pki | output | W (16) | Peak absolute current in the window |
| res_count | output | CW (16) | Samples in the window |

## Verification
Constant samples confirm the basic sums and exact means without any truncation effect. Ramps that wrap through both signs and mixed-sign offsets show whether truncation toward zero and offset addition are done correctly. A full-scale negative constant exercises the largest square, the -32768 magnitude and the accumulator width. Line-locked runs with different flag spacings, including a zero flag target, show the window following the flags and not `cfg_n`. A continuous two-window stream with a held-off consumer separates correct back-pressure and peak restart from lost or doubled samples, and a stop in mid-window shows that a partial window is dropped.

// File: rtl/pwravg_pkg.sv
package pwravg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_DIV  = 2'd2,
    ST_OUT  = 2'd3
  } pa_state_e;

  // lane order of the accumulator bank
  localparam int LANE_V2 = 0;
  localparam int LANE_I2 = 1;
  localparam int LANE_P  = 2;
  localparam int LANE_Q  = 3;
  localparam int N_LANES = 4;
endpackage

// File: rtl/pwravg_window.sv
module pwravg_window #(
  parameter int CW    = 16,
  parameter int HW    = 16,
  parameter int MIN_N = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          hs,
  input  logic          zc,
  input  logic          sync,
  input  logic [CW-1:0] cfg_n,
  input  logic [HW-1:0] cfg_hc,
  output logic          close,
  output logic [CW-1:0] n_next
);
  localparam logic [CW-1:0] MIN_V = CW'(MIN_N);

  logic [CW-1:0] cnt;
  logic [HW-1:0] zcnt;
  logic [CW-1:0] n_eff;
  logic [HW-1:0] hc_eff;

  always_comb begin
    n_eff  = (cfg_n < MIN_V) ? MIN_V : cfg_n;
    hc_eff = (cfg_hc == '0) ? HW'(1) : cfg_hc;
    n_next = (cnt == '1) ? cnt : cnt + 1'b1;
    if (sync) close = hs && zc && ((zcnt + 1'b1) >= hc_eff);
    else      close = hs && (n_next >= n_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      zcnt <= '0;
    end else if (clear || close) begin
      cnt  <= '0;
      zcnt <= '0;
    end else if (hs) begin
      cnt <= n_next;
      if (zc && zcnt != '1) zcnt <= zcnt + 1'b1;
    end
  end

  // R2
  win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |-> cnt < n_eff);
endmodule

// File: rtl/pwravg_accum.sv
module pwravg_accum #(
  parameter int W  = 16,
  parameter int AW = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 hs,
  input  logic signed [W-1:0]  v,
  input  logic signed [W-1:0]  i,
  input  logic signed [W-1:0]  q,
  output logic [3:0][AW-1:0]   acc,
  output logic [1:0][W-1:0]    pk,
  output logic [1:0][W-1:0]    pk_nxt
);
  import pwravg_pkg::*;

  logic signed [W-1:0] opa [N_LANES];
  logic signed [W-1:0] opb [N_LANES];
  logic signed [W-1:0] chn [2];

  always_comb begin
    opa[LANE_V2] = v; opb[LANE_V2] = v;
    opa[LANE_I2] = i; opb[LANE_I2] = i;
    opa[LANE_P]  = v; opb[LANE_P]  = i;
    opa[LANE_Q]  = i; opb[LANE_Q]  = q;
    chn[0] = v;
    chn[1] = i;
  end

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic signed [2*W-1:0] prod;
    assign prod = opa[g] * opb[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     acc[g] <= '0;
      else if (clear) acc[g] <= '0;
      else if (hs)    acc[g] <= acc[g] + AW'(prod);
    end
  end

  for (genvar c = 0; c < 2; c++) begin : g_peak
    logic [W-1:0] mag;
    assign mag       = chn[c][W-1] ? W'(-chn[c]) : W'(chn[c]);
    assign pk_nxt[c] = (mag > pk[c]) ? mag : pk[c];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pk[c] <= '0;
      else if (clear) pk[c] <= '0;
      else if (hs)    pk[c] <= pk_nxt[c];
    end

    // R6
    peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> pk[c] >= $past(pk[c]));
  end
endmodule

// File: rtl/pwravg_divider.sv
module pwravg_divider #(
  parameter int DW = 64,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] dividend,
  input  logic [CW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quot
);
  localparam int SW = $clog2(DW + 1);

  logic [DW-1:0] qr;
  logic [CW-1:0] rem;
  logic [CW-1:0] dv;
  logic [SW-1:0] steps;
  logic [CW:0]   sh;
  logic          fits;

  assign sh   = {rem, qr[DW-1]};
  assign fits = sh >= {1'b0, dv};
  assign quot = qr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qr <= '0; rem <= '0; dv <= '0; steps <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        qr    <= dividend;
        rem   <= '0;
        dv    <= divisor;
        steps <= SW'(DW);
        busy  <= 1'b1;
      end else if (busy) begin
        qr    <= {qr[DW-2:0], fits};
        rem   <= fits ? CW'(sh - {1'b0, dv}) : sh[CW-1:0];
        steps <= steps - 1'b1;
        if (steps == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R3
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rem < dv);
endmodule

// File: rtl/pwr_avg_engine.sv
module pwr_avg_engine #(
  parameter int W     = 16,
  parameter int CW    = 16,
  parameter int HW    = 16,
  parameter int AW    = 64,
  parameter int MIN_N = 100
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 stop,
  input  logic                 cfg_sync,
  input  logic [CW-1:0]        cfg_n,
  input  logic [HW-1:0]        cfg_hc,
  input  logic [2*W-1:0]       cfg_p_off,
  input  logic [2*W-1:0]       cfg_q_off,
  input  logic                 smp_valid,
  output logic                 smp_ready,
  input  logic [W-1:0]         smp_v,
  input  logic [W-1:0]         smp_i,
  input  logic [W-1:0]         smp_q,
  input  logic                 smp_zc,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [2*W-1:0]       res_v2,
  output logic [2*W-1:0]       res_i2,
  output logic [2*W:0]         res_p,
  output logic [2*W:0]         res_q,
  output logic [W-1:0]         res_pkv,
  output logic [W-1:0]         res_pki,
  output logic [CW-1:0]        res_count
);
  import pwravg_pkg::*;

  localparam int RW = 2 * W + 1;

  pa_state_e          st;
  logic               run;
  logic [1:0]         sel;
  logic               div_go, div_busy, div_done;
  logic [AW-1:0]      div_q;
  logic [3:0][AW-1:0] acc;
  logic [1:0][W-1:0]  pk, pk_nxt;
  logic               hs, close, acc_clear, win_clear;
  logic [CW-1:0]      n_next;
  logic [AW-1:0]      op, mag, qs;
  logic               neg;
  logic [RW-1:0]      p_sum, q_sum;

  assign smp_ready = (st == ST_ACC);
  assign res_valid = (st == ST_OUT);
  assign hs        = smp_valid && smp_ready;
  assign acc_clear = ((st == ST_IDLE) && start && !stop) ||
                     ((st == ST_OUT) && res_ready && run && !stop);
  assign win_clear = acc_clear || stop;

  pwravg_window #(.CW(CW), .HW(HW), .MIN_N(MIN_N)) u_win (
    .clk(clk), .rst_n(rst_n), .clear(win_clear), .hs(hs), .zc(smp_zc),
    .sync(cfg_sync), .cfg_n(cfg_n), .cfg_hc(cfg_hc),
    .close(close), .n_next(n_next)
  );

  pwravg_accum #(.W(W), .AW(AW)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear(acc_clear), .hs(hs),
    .v(smp_v), .i(smp_i), .q(smp_q),
    .acc(acc), .pk(pk), .pk_nxt(pk_nxt)
  );

  pwravg_divider #(.DW(AW), .CW(CW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(mag), .divisor(res_count),
    .busy(div_busy), .done(div_done), .quot(div_q)
  );

  always_comb begin
    op    = acc[sel];
    neg   = op[AW-1];
    mag   = neg ? -op : op;
    qs    = neg ? -div_q : div_q;
    p_sum = RW'(qs) + {cfg_p_off[2*W-1], cfg_p_off};
    q_sum = RW'(qs) + {cfg_q_off[2*W-1], cfg_q_off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; run <= 1'b0; sel <= '0; div_go <= 1'b0;
      res_v2 <= '0; res_i2 <= '0; res_p <= '0; res_q <= '0;
      res_pkv <= '0; res_pki <= '0; res_count <= '0;
    end else begin
      div_go <= 1'b0;
      if (stop) run <= 1'b0;
      unique case (st)
        ST_IDLE: if (start && !stop) begin
          run <= 1'b1;
          st  <= ST_ACC;
        end
        ST_ACC: begin
          if (stop) st <= ST_IDLE;
          else if (close) begin
            res_count <= n_next;
            res_pkv   <= pk_nxt[0];
            res_pki   <= pk_nxt[1];
            sel       <= '0;
            div_go    <= 1'b1;
            st        <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          unique case (sel)
            2'd0: res_v2 <= div_q[2*W-1:0];
            2'd1: res_i2 <= div_q[2*W-1:0];
            2'd2: res_p  <= p_sum;
            default: res_q <= q_sum;
          endcase
          if (sel == 2'd3) st <= ST_OUT;
          else begin
            sel    <= sel + 1'b1;
            div_go <= 1'b1;
          end
        end
        default: if (res_ready) st <= (run && !stop) ? ST_ACC : ST_IDLE;
      endcase
    end
  end

  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !smp_ready);

  // R8
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_p) && $stable(res_q)
      && $stable(res_v2) && $stable(res_count) && $stable(res_pkv));

  // R3
  meansq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_v2 <= res_pkv * res_pkv) && (res_i2 <= res_pki * res_pki));

  // R9
  stop_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACC) && stop |=> !smp_ready && !res_valid);
endmodule

// File: tb/pwr_avg_engine_tb.sv
module pwr_avg_engine_tb;
  logic clk = 0;
  logic rst_n = 0;
  always #10 clk = ~clk;

  logic start = 0, stop = 0, cfg_sync = 0;
  logic [15:0] cfg_n = 16'd100, cfg_hc = 16'd1;
  logic [31:0] cfg_p_off = 0, cfg_q_off = 0;
  logic smp_valid = 0, smp_zc = 0, res_ready = 0;
  logic [15:0] smp_v = 0, smp_i = 0, smp_q = 0;
  logic smp_ready, res_valid;
  logic [31:0] res_v2, res_i2;
  logic [32:0] res_p, res_q;
  logic [15:0] res_pkv, res_pki, res_count;

  pwr_avg_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cfg_sync(cfg_sync),
    .cfg_n(cfg_n), .cfg_hc(cfg_hc), .cfg_p_off(cfg_p_off), .cfg_q_off(cfg_q_off),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .smp_v(smp_v), .smp_i(smp_i),
    .smp_q(smp_q), .smp_zc(smp_zc), .res_valid(res_valid), .res_ready(res_ready),
    .res_v2(res_v2), .res_i2(res_i2), .res_p(res_p), .res_q(res_q),
    .res_pkv(res_pkv), .res_pki(res_pki), .res_count(res_count)
  );

  typedef struct packed {
    int sync; int n; int hc; int zcp;
    int va; int vd; int ia; int id; int qa; int qd; int po; int qo;
  } vec_t;

  localparam vec_t VT [5] = '{
    '{0, 100, 1, 7,   1000, 0, -500, 0, 300, 0, 0, 0},
    '{0, 50,  1, 7,   -30000, 613, 20000, -411, 7, 997, 12345, -777},
    '{0, 257, 1, 7,   -32768, 0, -32768, 0, 32767, 0, -5, 0},
    '{1, 100, 3, 40,  100, -250, -3000, 57, 15000, -301, -1000, 2000},
    '{1, 999, 0, 150, 5, 9001, 77, -3333, -9, 123, 0, 0}
  };

  int nchk = 0, nfail = 0, cyc = 0;

  task automatic chk(string tag, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  function automatic logic signed [15:0] gen(int a, int d, int k);
    return 16'(a + k * d);
  endfunction

  task automatic send(logic [15:0] v, logic [15:0] i, logic [15:0] q, logic zc);
    @(negedge clk);
    while (!smp_ready) @(negedge clk);
    smp_valid = 1; smp_v = v; smp_i = i; smp_q = q; smp_zc = zc;
    @(posedge clk);
    #1 smp_valid = 0; smp_zc = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic take(input int hold, output longint o[7]);
    @(negedge clk);
    while (!res_valid) @(negedge clk);
    o[0] = res_count; o[1] = res_v2; o[2] = res_i2;
    o[3] = longint'($signed(res_p)); o[4] = longint'($signed(res_q));
    o[5] = res_pkv; o[6] = res_pki;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R8 result held", longint'($signed(res_p)), o[3]);
      chk("R8 input stalled", longint'(smp_ready), 0);
    end
    res_ready = 1; @(negedge clk); res_ready = 0;
  endtask

  // expected results for samples k0..k0+n-1 of a vector
  task automatic expect_win(vec_t t, int k0, int n, output longint e[7]);
    longint s2v = 0, s2i = 0, sp = 0, sq = 0, pv = 0, pi = 0;
    for (int k = k0; k < k0 + n; k++) begin
      longint v, i, q;
      v = gen(t.va, t.vd, k); i = gen(t.ia, t.id, k); q = gen(t.qa, t.qd, k);
      s2v += v * v; s2i += i * i; sp += v * i; sq += i * q;
      if ((v < 0 ? -v : v) > pv) pv = v < 0 ? -v : v;
      if ((i < 0 ? -i : i) > pi) pi = i < 0 ? -i : i;
    end
    e[0] = n; e[1] = s2v / n; e[2] = s2i / n;
    e[3] = sp / n + t.po; e[4] = sq / n + t.qo; e[5] = pv; e[6] = pi;
  endtask

  task automatic cmp(longint o[7], longint e[7], string r);
    chk({r, " count R2/R7"}, o[0], e[0]);
    chk({r, " mean v2 R3"}, o[1], e[1]);
    chk({r, " mean i2 R3"}, o[2], e[2]);
    chk({r, " active R4"}, o[3], e[3]);
    chk({r, " reactive R5"}, o[4], e[4]);
    chk({r, " peak v R6"}, o[5], e[5]);
    chk({r, " peak i R6"}, o[6], e[6]);
  endtask

  initial begin
    longint o[7], e[7];
    vec_t t;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 res_valid", longint'(res_valid), 0);
    chk("R1 smp_ready", longint'(smp_ready), 0);
    chk("R1 res_count", longint'(res_count), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle ready", longint'(smp_ready), 0);

    // table walk: R2..R7
    for (int x = 0; x < 5; x++) begin
      int n;
      t = VT[x];
      cfg_sync = t.sync[0]; cfg_n = 16'(t.n); cfg_hc = 16'(t.hc);
      cfg_p_off = 32'(t.po); cfg_q_off = 32'(t.qo);
      if (t.sync != 0) n = (t.hc == 0 ? 1 : t.hc) * t.zcp;
      else             n = (t.n < 100) ? 100 : t.n;
      pulse_start();
      for (int k = 0; k < n; k++)
        send(gen(t.va, t.vd, k), gen(t.ia, t.id, k), gen(t.qa, t.qd, k),
             (t.sync != 0) ? ((k + 1) % t.zcp == 0) : (k % 7 == 3));
      take(0, o);
      expect_win(t, 0, n, e);
      cmp(o, e, $sformatf("vec%0d", x));
      pulse_stop();
    end

    // R9: partial window dropped, then fresh window
    t = VT[0];
    cfg_sync = 0; cfg_n = 16'd100; cfg_p_off = 0; cfg_q_off = 0;
    pulse_start();
    for (int k = 0; k < 60; k++) send(16'd9000, 16'd9000, 16'd9000, 1'b0);
    pulse_stop();
    repeat (300) @(negedge clk);
    chk("R9 no result after stop", longint'(res_valid), 0);
    pulse_start();
    for (int k = 0; k < 100; k++)
      send(gen(t.va, t.vd, k), gen(t.ia, t.id, k), gen(t.qa, t.qd, k), 1'b0);
    take(0, o);
    expect_win(t, 0, 100, e);
    cmp(o, e, "R9 fresh");
    pulse_stop();

    // R8/R6: continuous stream over two windows with held-off consumer
    t = '{0, 100, 1, 7, -20000, 150, 1234, -25, 50, 3, 7, -7};
    cfg_p_off = 32'(t.po); cfg_q_off = 32'(t.qo);
    pulse_start();
    fork
      for (int k = 0; k < 200; k++)
        send(gen(t.va, t.vd, k), gen(t.ia, t.id, k), gen(t.qa, t.qd, k), 1'b0);
      begin
        take(20, o);
        expect_win(t, 0, 100, e);
        cmp(o, e, "R8 win A");
        take(0, o);
        expect_win(t, 100, 100, e);
        cmp(o, e, "R8 win B");
      end
    join
    pulse_stop();

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule